// File: doc/BRIEF.md
# Cache Victim Selector with Runtime Replacement Policy

This unit decides which way of a set-associative cache should be evicted next. It keeps replacement state for every way of every set and, when asked for a set, returns one way number. The cache controller reports each hit and each line fill with a set index and a way. The unit updates its recency ranks, fill pointers and hit counters from those reports. Tags, data arrays and the cache datapath belong to the surrounding controller.

A two-bit policy input picks one of four rules at run time: least recently used, round-robin in fill order, least frequently hit, or pseudo-random. All four rules read the same state, and that state is kept up to date under every policy. The policy can therefore be switched at any moment without a warm-up period. A way that has not been filled since reset is always taken before any valid way.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset every way of every set is invalid, `victim_valid_o` is low, and a request to any set returns way 0.
- R2: If the requested set holds any invalid way, the victim is the lowest-numbered invalid way, whatever the policy. A fill marks its way valid.
- R3: `victim_valid_o` is high in exactly the cycle after a cycle with `req_i` high. `victim_way_o` then shows a way below NUM_WAYS, chosen from the state before that edge. A hit or fill presented in the same cycle as the request takes effect at that same edge.
- R4: Policy code 0 (LRU): with all ways valid, the victim is the way whose last hit or fill is oldest.
- R5: Policy code 1 (FIFO): each set has a pointer that is 0 after reset and steps by one, wrapping after NUM_WAYS-1, on every fill to that set. Hits leave it alone. The victim is the pointer value.
- R6: Policy code 2 (LFU): the victim is the way with the smallest hit count. When counts are equal, the lowest-numbered way wins.
- R7: Hit counters stop at 2^CNT_W-1 instead of wrapping. A fill to a way clears that way's counter to zero.
- R8: Policy code 3 (random): the victim is a free-running 16-bit LFSR value modulo NUM_WAYS. Repeated requests to one set spread over several ways.
- R9: Hits and fills change only the set they name. Other sets keep their state.
- R10: When a fill and a hit name the same set in the same cycle, only the fill updates that set, and the hit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Replacement rule: 0 LRU, 1 FIFO, 2 LFU, 3 random |
| req_i | input | 1 | Victim request |
| req_set_i | input | SET_W | Set of the request |
| hit_i | input | 1 | Hit notification |
| hit_set_i | input | SET_W | Set of the hit |
| hit_way_i | input | WAY_W | Way of the hit |
| fill_i | input | 1 | Fill notification |
| fill_set_i | input | SET_W | Set of the fill |
| fill_way_i | input | WAY_W | Way of the fill |
| victim_valid_o | output | 1 | Victim result valid |
| victim_way_o | output | WAY_W | Way chosen for eviction |

## Verification
The assertions take for granted that every way index the controller reports is below NUM_WAYS. They also assume a hit names only a way that has already been filled, so hit counts and recency ranks only ever describe resident lines. The directed stimulus keeps to this: it fills each set before it sends hits to that set. The only ways it names are 0 to 3 of the default four-way configuration, and it exercises the fill-over-hit collision on purpose.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_LFU  = 2'd2,
    POL_RAND = 2'd3
  } policy_e;

  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/cvs_lfsr.sv
module cvs_lfsr (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] rnd_o
);
  import cvs_pkg::*;

  logic [15:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LFSR_SEED;
    else         q <= {1'b0, q[15:1]} ^ (q[0] ? LFSR_TAPS : 16'h0000);
  end

  assign rnd_o = q;

  p_lfsr_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) q != 16'h0000)
    else $error("lfsr locked at zero");
endmodule

// File: rtl/cvs_set_state.sv
module cvs_set_state #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                hit_i,
  input  logic [WAY_W-1:0]                    hit_way_i,
  input  logic                                fill_i,
  input  logic [WAY_W-1:0]                    fill_way_i,
  output logic [NUM_WAYS-1:0]                 valid_o,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]      age_o,
  output logic [NUM_WAYS-1:0][CNT_W-1:0]      cnt_o,
  output logic [WAY_W-1:0]                    ptr_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic [NUM_WAYS-1:0]            valid_q;
  logic [NUM_WAYS-1:0][WAY_W-1:0] age_q;
  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt_q;
  logic [WAY_W-1:0]               ptr_q;
  logic                           acc_en;
  logic [WAY_W-1:0]               acc_way;

  // fill takes precedence over a hit to the same set
  assign acc_en  = fill_i | hit_i;
  assign acc_way = fill_i ? fill_way_i : hit_way_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < NUM_WAYS; i++) age_q[i] <= WAY_W'(i);
    end else begin
      if (acc_en) begin
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (WAY_W'(i) == acc_way)          age_q[i] <= '0;
          else if (age_q[i] < age_q[acc_way]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (fill_i) begin
        valid_q[fill_way_i] <= 1'b1;
        cnt_q[fill_way_i]   <= '0;
        ptr_q               <= (ptr_q == LAST_WAY) ? '0 : ptr_q + 1'b1;
      end else if (hit_i && (cnt_q[hit_way_i] != {CNT_W{1'b1}})) begin
        cnt_q[hit_way_i] <= cnt_q[hit_way_i] + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign age_o   = age_q;
  assign cnt_o   = cnt_q;
  assign ptr_o   = ptr_q;

  logic [NUM_WAYS-1:0] oldest;
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) oldest[i] = (age_q[i] == LAST_WAY);
  end

  p_one_oldest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1) else $error("recency ranks not a permutation");

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way_chk
    p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && !fill_i && hit_way_i == WAY_W'(g) && cnt_q[g] == {CNT_W{1'b1}})
      |=> cnt_q[g] == {CNT_W{1'b1}}) else $error("hit counter wrapped");
    p_fill_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fill_i && fill_way_i == WAY_W'(g))
      |=> (cnt_q[g] == '0 && valid_q[g] && age_q[g] == '0)) else $error("fill did not renew way");
  end

  if (NUM_WAYS > 1) begin : g_ptr_chk
    p_ptr_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_i |=> ptr_q != $past(ptr_q)) else $error("fifo pointer stuck on fill");
  end
endmodule

// File: rtl/cvs_pick.sv
module cvs_pick #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic [1:0]                      policy_i,
  input  logic [NUM_WAYS-1:0]             valid_i,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0]  age_i,
  input  logic [NUM_WAYS-1:0][CNT_W-1:0]  cnt_i,
  input  logic [WAY_W-1:0]                ptr_i,
  input  logic [15:0]                     rnd_i,
  output logic [WAY_W-1:0]                way_o
);
  import cvs_pkg::*;

  if (NUM_WAYS == 1) begin : g_direct
    assign way_o = '0;
  end else begin : g_assoc
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
    policy_e          pol;
    logic             found;
    logic [CNT_W-1:0] best;
    logic [WAY_W-1:0] way;

    assign pol = policy_e'(policy_i);

    always_comb begin
      way   = '0;
      found = 1'b0;
      best  = cnt_i[0];
      for (int i = 0; i < NUM_WAYS; i++) begin
        if (!valid_i[i] && !found) begin
          way   = WAY_W'(i);
          found = 1'b1;
        end
      end
      if (!found) begin
        unique case (pol)
          POL_LRU: begin
            for (int i = 0; i < NUM_WAYS; i++)
              if (age_i[i] == LAST_WAY) way = WAY_W'(i);
          end
          POL_FIFO: way = ptr_i;
          POL_LFU: begin
            for (int i = 1; i < NUM_WAYS; i++) begin
              if (cnt_i[i] < best) begin
                best = cnt_i[i];
                way  = WAY_W'(i);
              end
            end
          end
          POL_RAND: way = WAY_W'(rnd_i % 16'(NUM_WAYS));
          default:  way = '0;
        endcase
      end
    end

    assign way_o = way;
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 3,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       policy_i,
  input  logic             req_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic             hit_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  output logic             victim_valid_o,
  output logic [WAY_W-1:0] victim_way_o
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid_s;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] age_s;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] cnt_s;
  logic [NUM_SETS-1:0][WAY_W-1:0]               ptr_s;
  logic [15:0]                                  rnd;
  logic [WAY_W-1:0]                             pick_way;
  logic                                         vld_q;
  logic [WAY_W-1:0]                             way_q;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    cvs_set_state #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit_i && (hit_set_i == SET_W'(s))),
      .hit_way_i  (hit_way_i),
      .fill_i     (fill_i && (fill_set_i == SET_W'(s))),
      .fill_way_i (fill_way_i),
      .valid_o    (valid_s[s]),
      .age_o      (age_s[s]),
      .cnt_o      (cnt_s[s]),
      .ptr_o      (ptr_s[s])
    );
  end

  cvs_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  cvs_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_pick (
    .policy_i (policy_i),
    .valid_i  (valid_s[req_set_i]),
    .age_i    (age_s[req_set_i]),
    .cnt_i    (cnt_s[req_set_i]),
    .ptr_i    (ptr_s[req_set_i]),
    .rnd_i    (rnd),
    .way_o    (pick_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      way_q <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) way_q <= pick_way;
    end
  end

  assign victim_valid_o = vld_q;
  assign victim_way_o   = way_q;

  p_way_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (int'(victim_way_o) < NUM_WAYS)) else $error("victim way out of range");
endmodule

// File: tb/sim_cache_victim_sel.sv
module sim_cache_victim_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] policy_i = 2'd0;
  logic       req_i = 1'b0;
  logic [2:0] req_set_i = '0;
  logic       hit_i = 1'b0;
  logic [2:0] hit_set_i = '0;
  logic [1:0] hit_way_i = '0;
  logic       fill_i = 1'b0;
  logic [2:0] fill_set_i = '0;
  logic [1:0] fill_way_i = '0;
  logic       victim_valid_o;
  logic [1:0] victim_way_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cache_victim_sel u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i),
    .req_i(req_i), .req_set_i(req_set_i),
    .hit_i(hit_i), .hit_set_i(hit_set_i), .hit_way_i(hit_way_i),
    .fill_i(fill_i), .fill_set_i(fill_set_i), .fill_way_i(fill_way_i),
    .victim_valid_o(victim_valid_o), .victim_way_o(victim_way_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int s, input int w);
    fill_i = 1'b1; fill_set_i = 3'(s); fill_way_i = 2'(w);
    @(negedge clk_i);
    fill_i = 1'b0;
  endtask

  task automatic hit(input int s, input int w, input int times);
    for (int k = 0; k < times; k++) begin
      hit_i = 1'b1; hit_set_i = 3'(s); hit_way_i = 2'(w);
      @(negedge clk_i);
      hit_i = 1'b0;
    end
  endtask

  task automatic query(input int s, input int pol, input int exp, input string req);
    req_i = 1'b1; req_set_i = 3'(s); policy_i = 2'(pol);
    @(negedge clk_i);
    req_i = 1'b0;
    check(victim_valid_o == 1'b1, "R3 valid after request", int'(victim_valid_o), 1);
    check(int'(victim_way_o) == exp, req, int'(victim_way_o), exp);
  endtask

  task automatic t_reset();
    check(victim_valid_o == 1'b0, "R1 valid low after reset", int'(victim_valid_o), 0);
    for (int p = 0; p < 4; p++) query(p + 1, p, 0, "R1 empty set gives way 0");
    @(negedge clk_i);
    check(victim_valid_o == 1'b0, "R3 valid one cycle only", int'(victim_valid_o), 0);
  endtask

  task automatic t_invalid_first();
    fill(1, 0);
    fill(1, 2);
    query(1, 1, 1, "R2 lowest invalid under FIFO");
    query(1, 0, 1, "R2 lowest invalid under LRU");
    query(1, 2, 1, "R2 lowest invalid under LFU");
  endtask

  task automatic t_lru();
    for (int w = 0; w < 4; w++) fill(2, w);
    query(2, 0, 0, "R4 oldest fill");
    hit(2, 0, 1);
    query(2, 0, 1, "R4 after hit way0");
    hit(2, 1, 1);
    hit(2, 2, 1);
    query(2, 0, 3, "R4 after hits 1,2");
    // request and hit together: result reflects pre-hit state
    req_i = 1'b1; req_set_i = 3'd2; policy_i = 2'd0;
    hit_i = 1'b1; hit_set_i = 3'd2; hit_way_i = 2'd3;
    @(negedge clk_i);
    req_i = 1'b0; hit_i = 1'b0;
    check(victim_way_o == 2'd3, "R3 pre-update state", int'(victim_way_o), 3);
    query(2, 0, 0, "R3 hit applied at same edge");
  endtask

  task automatic t_fifo();
    for (int w = 0; w < 4; w++) fill(3, w);
    query(3, 1, 0, "R5 pointer wrapped to 0");
    fill(3, 0);
    query(3, 1, 1, "R5 pointer advanced on fill");
    hit(3, 1, 2);
    query(3, 1, 1, "R5 hits do not move pointer");
  endtask

  task automatic t_lfu();
    for (int w = 0; w < 4; w++) fill(4, w);
    hit(4, 0, 2);
    hit(4, 1, 1);
    hit(4, 2, 1);
    query(4, 2, 3, "R6 fewest hits");
    hit(4, 3, 1);
    query(4, 2, 1, "R6 tie goes to lowest way");
    hit(4, 0, 6);
    hit(4, 2, 9);
    hit(4, 3, 9);
    hit(4, 1, 20);
    query(4, 2, 0, "R7 counters saturate not wrap");
    fill(4, 2);
    query(4, 2, 2, "R7 fill clears counter");
    query(6, 2, 0, "R9 untouched set stays empty");
    query(3, 1, 1, "R9 other set pointer unchanged");
  endtask

  task automatic t_collision();
    for (int w = 0; w < 4; w++) fill(7, w);
    hit(7, 0, 1);
    fill_i = 1'b1; fill_set_i = 3'd7; fill_way_i = 2'd3;
    hit_i = 1'b1; hit_set_i = 3'd7; hit_way_i = 2'd1;
    @(negedge clk_i);
    fill_i = 1'b0; hit_i = 1'b0;
    query(7, 2, 1, "R10 hit dropped on same-set fill");
  endtask

  task automatic t_random();
    logic [3:0] seen = '0;
    for (int w = 0; w < 4; w++) fill(5, w);
    for (int k = 0; k < 40; k++) begin
      req_i = 1'b1; req_set_i = 3'd5; policy_i = 2'd3;
      @(negedge clk_i);
      req_i = 1'b0;
      seen[victim_way_o] = 1'b1;
      @(negedge clk_i);
    end
    check($countones(seen) >= 2, "R8 random spreads over ways", $countones(seen), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_invalid_first();
    t_lru();
    t_fifo();
    t_lfu();
    t_collision();
    t_random();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule